// File: doc/BRIEF.md
# SD/MMC host interrupt pending and mask unit

This block gathers the event indications of an SD/MMC host controller into one pending register and drives a single interrupt line to the processor. Four sources are sticky flags: data transfer done, programming done, command response end and the card interrupt. Each is set by a one-cycle input pulse and stays set until software clears it. Two further sources are level requests. They are computed every cycle from the receive and transmit FIFO fill counts, which the block receives as inputs.

Software sees the pending and mask registers as plain outputs. It writes through a single write port, where a select bit chooses between the two registers. A write to the pending register clears every bit written as one. A write to the mask register replaces the whole mask. The mask has inverted sense: a one blocks its source. The interrupt line is high when any pending bit has a zero in the mask.

Top module: `mmc_irq_ctrl`

## Requirements
- R1: In reset, and in the first cycle after it, the pending register is 0x00, the mask is 0xFF and the interrupt line is low.
- R2: A pulse on an event input sets its pending bit at the next clock edge: transfer done sets bit 0, programming done sets bit 1, command end sets bit 2 and the card interrupt sets bit 7. The bit then stays set until it is cleared.
- R3: A pending write (wr_en=1, wr_sel=0) clears each sticky bit whose wr_data bit is 1. Bits written as 0 are left unchanged.
- R4: When an event pulse and a clearing write of the same bit fall in the same cycle, the bit is set after the edge.
- R5: Bit 5 (receive request) is 1 after an edge exactly when rx_level at that edge was 8 or more.
- R6: Bit 6 (transmit request) is 1 after an edge exactly when tx_level at that edge was below 8.
- R7: Pending writes have no effect on bits 5 and 6.
- R8: Bits 3 and 4 of the pending register always read 0, whatever the writes and inputs.
- R9: A mask write (wr_en=1, wr_sel=1) loads wr_data into the mask at the next edge. A mask bit of 1 disables that source.
- R10: irq_o is registered. After each edge it equals the OR over all bits of pending AND NOT mask, taken from the register values just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_xfer_done | input | 1 | Data transfer done pulse |
| ev_prog_done | input | 1 | Programming done pulse |
| ev_cmd_end | input | 1 | Command response end pulse |
| ev_card_irq | input | 1 | Card interrupt pulse |
| rx_level | input | LVL_W | Receive FIFO fill count in words |
| tx_level | input | LVL_W | Transmit FIFO fill count in words |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = pending clear write, 1 = mask write |
| wr_data | input | 8 | Write data |
| pending_o | output | 8 | Pending register |
| mask_o | output | 8 | Mask register |
| irq_o | output | 1 | Interrupt request line |

## Verification
Event pulses, clearing writes, mask writes and FIFO level changes each show in pending_o or mask_o one edge after they are driven. irq_o follows one edge after that, so it is due two edges after an event or a mask change. The bench drives its inputs on the falling edge. It reads pending_o and mask_o at the next falling edge and irq_o one falling edge later. The checks for cleared and masked state are made at the same points, so a late or early change of a bit is reported as a mismatch.

// File: rtl/mmc_irq_pkg.sv
package mmc_irq_pkg;
  localparam int IRQ_W = 8;
  localparam int B_XFER = 0;
  localparam int B_PROG = 1;
  localparam int B_CMD  = 2;
  localparam int B_RXRQ = 5;
  localparam int B_TXRQ = 6;
  localparam int B_CARD = 7;
  // bit classes: sticky event flags, FIFO level requests, the rest unused
  localparam logic [IRQ_W-1:0] STICKY_BITS = IRQ_W'((1 << B_XFER) | (1 << B_PROG) | (1 << B_CMD) | (1 << B_CARD));
  localparam logic [IRQ_W-1:0] LEVEL_BITS  = IRQ_W'((1 << B_RXRQ) | (1 << B_TXRQ));
endpackage

// File: rtl/mmc_irq_fifo_req.sv
module mmc_irq_fifo_req #(
  parameter int LVL_W  = 5,
  parameter int THRESH = 8
) (
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  output logic             rx_req,
  output logic             tx_req
);
  localparam logic [LVL_W-1:0] TH = LVL_W'(THRESH);
  always_comb begin
    rx_req = (rx_level >= TH);
    tx_req = (tx_level < TH);
  end
endmodule

// File: rtl/mmc_irq_pending.sv
module mmc_irq_pending
  import mmc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic [IRQ_W-1:0] lvl_vec,
  input  logic             clr_en,
  input  logic [IRQ_W-1:0] clr_vec,
  output logic [IRQ_W-1:0] pend_q
);
  for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
    if (STICKY_BITS[b]) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst)
          pend_q[b] <= 1'b0;
        else if (set_vec[b])
          pend_q[b] <= 1'b1;
        else if (clr_en && clr_vec[b])
          pend_q[b] <= 1'b0;
      end
    end else if (LEVEL_BITS[b]) begin : g_level
      always_ff @(posedge clk) begin
        if (rst) pend_q[b] <= 1'b0;
        else     pend_q[b] <= lvl_vec[b];
      end
    end else begin : g_unused
      assign pend_q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/mmc_irq_mask_out.sv
module mmc_irq_mask_out
  import mmc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [IRQ_W-1:0] ld_val,
  input  logic [IRQ_W-1:0] pend,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (ld_en) mask_q <= ld_val;
      irq_q <= |(pend & ~mask_q);
    end
  end
endmodule

// File: rtl/mmc_irq_ctrl.sv
module mmc_irq_ctrl
  import mmc_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int THRESH     = FIFO_DEPTH / 2,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_xfer_done,
  input  logic             ev_prog_done,
  input  logic             ev_cmd_end,
  input  logic             ev_card_irq,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [7:0]       wr_data,
  output logic [7:0]       pending_o,
  output logic [7:0]       mask_o,
  output logic             irq_o
);
  logic rx_req, tx_req;
  logic [IRQ_W-1:0] set_vec, lvl_vec;

  mmc_irq_fifo_req #(.LVL_W(LVL_W), .THRESH(THRESH)) u_req (
    .rx_level(rx_level), .tx_level(tx_level), .rx_req(rx_req), .tx_req(tx_req)
  );

  always_comb begin
    set_vec = '0;
    set_vec[B_XFER] = ev_xfer_done;
    set_vec[B_PROG] = ev_prog_done;
    set_vec[B_CMD]  = ev_cmd_end;
    set_vec[B_CARD] = ev_card_irq;
    lvl_vec = '0;
    lvl_vec[B_RXRQ] = rx_req;
    lvl_vec[B_TXRQ] = tx_req;
  end

  mmc_irq_pending u_pend (
    .clk(clk), .rst(rst), .set_vec(set_vec), .lvl_vec(lvl_vec),
    .clr_en(wr_en && !wr_sel), .clr_vec(wr_data), .pend_q(pending_o)
  );

  mmc_irq_mask_out u_mask (
    .clk(clk), .rst(rst), .ld_en(wr_en && wr_sel), .ld_val(wr_data),
    .pend(pending_o), .mask_q(mask_o), .irq_q(irq_o)
  );
endmodule

// File: rtl/mmc_irq_ctrl_chk.sv
module mmc_irq_ctrl_chk #(
  parameter int THRESH = 8,
  parameter int LVL_W  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_cmd_end,
  input logic             ev_card_irq,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [7:0]       wr_data,
  input logic [7:0]       pending_o,
  input logic [7:0]       mask_o,
  input logic             irq_o
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pending_o == 8'h00 && mask_o == 8'hFF && !irq_o));
  p_cmd_sets_r2: assert property (@(posedge clk) disable iff (rst)
    ev_cmd_end |=> pending_o[2]);
  // R4: set wins over a simultaneous clear
  p_card_wins_r4: assert property (@(posedge clk) disable iff (rst)
    ev_card_irq && wr_en && !wr_sel && wr_data[7] |=> pending_o[7]);
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    pending_o[0] && !(wr_en && !wr_sel && wr_data[0]) |=> pending_o[0]);
  p_rx_high_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_level >= LVL_W'(THRESH)) |=> pending_o[5]);
  p_rx_low_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_level < LVL_W'(THRESH)) |=> !pending_o[5]);
  p_tx_low_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_level < LVL_W'(THRESH)) |=> pending_o[6]);
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
    pending_o[4:3] == 2'b00);
  p_mask_load_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_sel |=> mask_o == $past(wr_data));
  p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_o == |($past(pending_o) & ~$past(mask_o)));
endmodule

bind mmc_irq_ctrl mmc_irq_ctrl_chk #(.THRESH(THRESH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .ev_cmd_end(ev_cmd_end), .ev_card_irq(ev_card_irq),
  .rx_level(rx_level), .tx_level(tx_level), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .pending_o(pending_o), .mask_o(mask_o), .irq_o(irq_o)
);

// File: tb/test_mmc_irq_ctrl.sv
module test_mmc_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_xfer_done = 0, ev_prog_done = 0, ev_cmd_end = 0, ev_card_irq = 0;
  logic [LVL_W-1:0] rx_level = '0;
  logic [LVL_W-1:0] tx_level = LVL_W'(8);
  logic wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] pending_o, mask_o;
  logic irq_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmc_irq_ctrl i_mmc_irq_ctrl (
    .clk(clk), .rst(rst), .ev_xfer_done(ev_xfer_done), .ev_prog_done(ev_prog_done),
    .ev_cmd_end(ev_cmd_end), .ev_card_irq(ev_card_irq), .rx_level(rx_level),
    .tx_level(tx_level), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pending_o(pending_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_xfer_done = 0; ev_prog_done = 0; ev_cmd_end = 0; ev_card_irq = 0;
    wr_en = 0; wr_sel = 0; wr_data = '0;
  endtask

  // one edge: inputs set before the call, cleared after it, outputs sampled at the next falling edge
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic clear_all();
    wr_en = 1; wr_sel = 0; wr_data = 8'hFF; step();
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    check("R1 pending in reset", pending_o, 8'h00);
    check("R1 mask in reset", mask_o, 8'hFF);
    rst = 0;
    @(negedge clk);
    check("R1 pending after reset", pending_o, 8'h00);
    check("R1 mask after reset", mask_o, 8'hFF);
    check("R1 irq after reset", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_events_r2();
    ev_xfer_done = 1; step();
    check("R2 xfer done sets bit0", pending_o, 8'h01);
    ev_prog_done = 1; step();
    check("R2 prog done sets bit1", pending_o, 8'h03);
    ev_cmd_end = 1; ev_card_irq = 1; step();
    check("R2 cmd end and card set bits 2,7", pending_o, 8'h87);
    step(); step();
    check("R2 bits held", pending_o, 8'h87);
  endtask

  task automatic t_w1c_r3();
    wr_en = 1; wr_sel = 0; wr_data = 8'h05; step();
    check("R3 clear bits 0,2 only", pending_o, 8'h82);
    wr_en = 1; wr_sel = 0; wr_data = 8'h00; step();
    check("R3 zero write no change", pending_o, 8'h82);
    clear_all();
    check("R3 clear all", pending_o, 8'h00);
  endtask

  task automatic t_collide_r4();
    ev_xfer_done = 1; step();
    ev_xfer_done = 1; wr_en = 1; wr_sel = 0; wr_data = 8'h01; step();
    check("R4 set beats clear on set bit", pending_o, 8'h01);
    clear_all();
    ev_card_irq = 1; wr_en = 1; wr_sel = 0; wr_data = 8'h80; step();
    check("R4 set beats clear on clear bit", pending_o, 8'h80);
    clear_all();
  endtask

  task automatic t_rx_r5();
    rx_level = 5'd7; step();
    check("R5 rx 7 no request", pending_o, 8'h00);
    rx_level = 5'd8; step();
    check("R5 rx 8 request", pending_o, 8'h20);
    rx_level = 5'd16; step();
    check("R5 rx 16 request", pending_o, 8'h20);
    rx_level = 5'd0; step();
    check("R5 rx 0 drops", pending_o, 8'h00);
  endtask

  task automatic t_tx_r6();
    tx_level = 5'd7; step();
    check("R6 tx 7 request", pending_o, 8'h40);
    tx_level = 5'd0; step();
    check("R6 tx 0 request", pending_o, 8'h40);
    tx_level = 5'd8; step();
    check("R6 tx 8 no request", pending_o, 8'h00);
  endtask

  task automatic t_level_clear_r7();
    rx_level = 5'd9; tx_level = 5'd2; step();
    check("R7 both requests", pending_o, 8'h60);
    wr_en = 1; wr_sel = 0; wr_data = 8'h60; step();
    check("R7 clear write ignored", pending_o, 8'h60);
    rx_level = 5'd0; tx_level = 5'd8; step();
  endtask

  task automatic t_unused_r8();
    ev_xfer_done = 1; ev_prog_done = 1; ev_cmd_end = 1; ev_card_irq = 1; step();
    check("R8 bits 3,4 zero", pending_o & 8'h18, 8'h00);
    check("R8 full pattern", pending_o, 8'h87);
    clear_all();
  endtask

  task automatic t_mask_irq_r9_r10();
    ev_prog_done = 1; step();
    step();
    check("R10 masked source no irq", {7'd0, irq_o}, 8'h00);
    wr_en = 1; wr_sel = 1; wr_data = 8'hFD; step();
    check("R9 mask loaded", mask_o, 8'hFD);
    check("R10 irq not yet", {7'd0, irq_o}, 8'h00);
    step();
    check("R10 irq after unmask", {7'd0, irq_o}, 8'h01);
    wr_en = 1; wr_sel = 0; wr_data = 8'h02; step();
    check("R10 irq one edge after clear", {7'd0, irq_o}, 8'h01);
    step();
    check("R10 irq low after clear", {7'd0, irq_o}, 8'h00);
    wr_en = 1; wr_sel = 1; wr_data = 8'hBF; step();
    check("R9 mask unmasks tx request", mask_o, 8'hBF);
    tx_level = 5'd3; step(); step();
    check("R10 irq from tx request", {7'd0, irq_o}, 8'h01);
    tx_level = 5'd8; step(); step();
    check("R10 irq follows tx level", {7'd0, irq_o}, 8'h00);
    wr_en = 1; wr_sel = 1; wr_data = 8'hFF; step();
    check("R9 mask restore", mask_o, 8'hFF);
  endtask

  initial begin
    t_reset_r1();
    t_events_r2();
    t_w1c_r3();
    t_collide_r4();
    t_rx_r5();
    t_tx_r6();
    t_level_clear_r7();
    t_unused_r8();
    t_mask_irq_r9_r10();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule